// File: doc/BRIEF.md
# Interrupt Arbiter and Vector Selector

At each instruction boundary, this block picks one pending interrupt source for the CPU to service. It then hands the CPU the 8-bit type of that source. The sources are:

- internal faults, such as divide error, which carry their own type;
- software INT requests of any type from 00h to FFh;
- a coprocessor segment overrun request;
- an edge-triggered non-maskable request;
- a level-sensitive maskable request, whose type is fetched from an external controller through an acknowledge handshake;
- the single-step trap.

The block holds the interrupt-enable (IF) and trap (TF) flags. It clears both on entry to any handler. They are reloaded when a return-from-interrupt (IRET) is presented.

A non-maskable request is latched on its rising edge. It always uses type 2 and needs no acknowledge. While a non-maskable handler runs, the block refuses any further non-maskable, maskable, overrun or single-step service. This lasts until IRET or reset. An edge that arrives in that window is remembered and is served once the block lifts.

The chosen source leaves on a valid/ready channel. `svc_valid` rises with the type and source code, and it stays high with both values unchanged until `svc_ready` is seen high at a clock edge. While a service is being offered or an acknowledge is outstanding, the block takes no new decision. Boundary strobes, flag writes and IRET are all ignored in that time. The consumer applies back-pressure simply by holding `svc_ready` low.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `svc_valid`, `ack_req`, `if_flag`, `tf_flag` and `nmi_blocked` are all 0.
- R2: A decision is taken only when the block is idle and `boundary` is high. The winner is the first eligible source in this order, with these `svc_src` codes: fault 0, software INT 1, coprocessor overrun 2 (type 09h), non-maskable 3, maskable 4, single-step 5.
- R3: A rising edge on `nmi` sets a pending request that is served with type 02h and without `ack_req`. Holding `nmi` high yields only one service.
- R4: Accepting a non-maskable request sets `nmi_blocked`. While it is set, non-maskable, maskable, overrun and single-step requests are not served, but faults and software INT still are. IRET clears it.
- R5: A non-maskable edge that arrives while `nmi_blocked` is set stays pending and is served at the first boundary after IRET.
- R6: A maskable request (`intr` high) is eligible only when IF is 1. On acceptance, `ack_req` stays high until `ack_done`. The service is then offered with `ack_type` as its type.
- R7: With TF at 1 and nothing else eligible, a boundary yields type 01h.
- R8: Accepting any source clears IF and TF in the same clock edge.
- R9: When idle, `flag_we` loads IF and TF from `flag_if` and `flag_tf`. `iret` loads them from `iret_if` and `iret_tf`, and it takes priority over `flag_we`. When a flag write or IRET comes in the same cycle as `boundary`, it is applied before the decision. While the block is busy, both are ignored.
- R10: `svc_valid` holds with `svc_type` and `svc_src` stable until `svc_ready`. Boundary strobes seen while the block is busy have no effect.
- R11: Fault and software INT types pass through unchanged across the full 00h to FFh range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| exc_req | input | 1 | Internal fault request |
| exc_type | input | 8 | Fault type |
| sw_req | input | 1 | Software INT request |
| sw_type | input | 8 | Software INT type |
| cso_req | input | 1 | Coprocessor segment overrun request |
| nmi | input | 1 | Non-maskable request, rising-edge triggered |
| intr | input | 1 | Maskable request, level |
| ack_req | output | 1 | Acknowledge outstanding to external controller |
| ack_done | input | 1 | Acknowledge complete, `ack_type` valid |
| ack_type | input | 8 | Type supplied by external controller |
| flag_we | input | 1 | Write IF/TF |
| flag_if | input | 1 | IF value for write |
| flag_tf | input | 1 | TF value for write |
| iret | input | 1 | Return from interrupt |
| iret_if | input | 1 | IF value restored by IRET |
| iret_tf | input | 1 | TF value restored by IRET |
| svc_valid | output | 1 | Service offer valid |
| svc_ready | input | 1 | Consumer takes the offer |
| svc_type | output | 8 | Selected interrupt type |
| svc_src | output | 3 | Selected source code |
| if_flag | output | 1 | Current IF |
| tf_flag | output | 1 | Current TF |
| nmi_blocked | output | 1 | Non-maskable handler in service |

## Verification
Every result is due on a fixed cycle. A boundary decision shows on `svc_valid` or `ack_req` one edge after the boundary is sampled. The flag clear and `nmi_blocked` land on that same edge. An `ack_done` shows on `svc_valid` one edge later. A non-maskable edge becomes pending one edge after it is sampled, so the bench always leaves a full cycle between a pulse and the boundary that should see it. The bench drives inputs and samples outputs one nanosecond after each rising edge. Each check reads exactly the edge at which its result must have settled.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [2:0] {
    SRC_EXC  = 3'd0,
    SRC_SW   = 3'd1,
    SRC_CSO  = 3'd2,
    SRC_NMI  = 3'd3,
    SRC_INTR = 3'd4,
    SRC_STEP = 3'd5
  } irq_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACKW = 2'd1,
    ST_SHOW = 2'd2
  } arb_state_e;

  localparam int NUM_SRC = 6;
endpackage

// File: rtl/irq_nmi_track.sv
module irq_nmi_track (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin,
  input  logic take,
  input  logic rel,
  output logic pend,
  output logic blocked,
  output logic blocked_eff
);
  logic nmi_q;
  logic rise;

  assign rise        = nmi_pin & ~nmi_q;
  assign blocked_eff = blocked & ~rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q   <= 1'b0;
      pend    <= 1'b0;
      blocked <= 1'b0;
    end else begin
      nmi_q <= nmi_pin;
      if (rise)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
      if (take)      blocked <= 1'b1;
      else if (rel)  blocked <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic iret,
  input  logic iret_if,
  input  logic iret_tf,
  input  logic wr,
  input  logic wr_if,
  input  logic wr_tf,
  input  logic enter,
  output logic if_q,
  output logic tf_q,
  output logic if_eff,
  output logic tf_eff
);
  logic do_iret, do_wr;

  assign do_iret = upd_en & iret;
  assign do_wr   = upd_en & wr & ~iret;

  always_comb begin
    if_eff = if_q;
    tf_eff = tf_q;
    if (do_iret) begin
      if_eff = iret_if;
      tf_eff = iret_tf;
    end else if (do_wr) begin
      if_eff = wr_if;
      tf_eff = wr_tf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_q <= 1'b0;
      tf_q <= 1'b0;
    end else if (enter) begin
      if_q <= 1'b0;
      tf_q <= 1'b0;
    end else begin
      if_q <= if_eff;
      tf_q <= tf_eff;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_arb_pkg::*;
#(
  parameter int TYPE_W    = 8,
  parameter int NMI_TYPE  = 2,
  parameter int STEP_TYPE = 1,
  parameter int CSO_TYPE  = 9
) (
  input  logic              exc_req,
  input  logic [TYPE_W-1:0] exc_type,
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              cso_req,
  input  logic              nmi_pend,
  input  logic              intr,
  input  logic              if_eff,
  input  logic              tf_eff,
  input  logic              blk_eff,
  output logic              hit,
  output irq_src_e          src,
  output logic [TYPE_W-1:0] typ
);
  logic [NUM_SRC-1:0] req;
  logic [TYPE_W-1:0]  cand [NUM_SRC];

  always_comb begin
    req[SRC_EXC]  = exc_req;
    req[SRC_SW]   = sw_req;
    req[SRC_CSO]  = cso_req & ~blk_eff;
    req[SRC_NMI]  = nmi_pend & ~blk_eff;
    req[SRC_INTR] = intr & if_eff & ~blk_eff;
    req[SRC_STEP] = tf_eff & ~blk_eff;
    cand[SRC_EXC]  = exc_type;
    cand[SRC_SW]   = sw_type;
    cand[SRC_CSO]  = TYPE_W'(CSO_TYPE);
    cand[SRC_NMI]  = TYPE_W'(NMI_TYPE);
    cand[SRC_INTR] = '0;
    cand[SRC_STEP] = TYPE_W'(STEP_TYPE);
  end

  always_comb begin
    hit = 1'b0;
    src = SRC_EXC;
    typ = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        src = irq_src_e'(3'(i));
        typ = cand[i];
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int TYPE_W    = 8,
  parameter int NMI_TYPE  = 2,
  parameter int STEP_TYPE = 1,
  parameter int CSO_TYPE  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              exc_req,
  input  logic [TYPE_W-1:0] exc_type,
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              cso_req,
  input  logic              nmi,
  input  logic              intr,
  output logic              ack_req,
  input  logic              ack_done,
  input  logic [TYPE_W-1:0] ack_type,
  input  logic              flag_we,
  input  logic              flag_if,
  input  logic              flag_tf,
  input  logic              iret,
  input  logic              iret_if,
  input  logic              iret_tf,
  output logic              svc_valid,
  input  logic              svc_ready,
  output logic [TYPE_W-1:0] svc_type,
  output logic [2:0]        svc_src,
  output logic              if_flag,
  output logic              tf_flag,
  output logic              nmi_blocked
);
  arb_state_e        state_q;
  logic [TYPE_W-1:0] type_q;
  irq_src_e          src_q;
  logic              idle, accept, take_nmi;
  logic              nmi_pend, blk_eff, if_eff, tf_eff;
  logic              sel_hit;
  irq_src_e          sel_src;
  logic [TYPE_W-1:0] sel_type;

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle & boundary & sel_hit;
  assign take_nmi = accept & (sel_src == SRC_NMI);

  irq_nmi_track u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_pin    (nmi),
    .take       (take_nmi),
    .rel        (idle & iret),
    .pend       (nmi_pend),
    .blocked    (nmi_blocked),
    .blocked_eff(blk_eff)
  );

  irq_flag_unit u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (idle),
    .iret   (iret),
    .iret_if(iret_if),
    .iret_tf(iret_tf),
    .wr     (flag_we),
    .wr_if  (flag_if),
    .wr_tf  (flag_tf),
    .enter  (accept),
    .if_q   (if_flag),
    .tf_q   (tf_flag),
    .if_eff (if_eff),
    .tf_eff (tf_eff)
  );

  irq_prio_sel #(
    .TYPE_W   (TYPE_W),
    .NMI_TYPE (NMI_TYPE),
    .STEP_TYPE(STEP_TYPE),
    .CSO_TYPE (CSO_TYPE)
  ) u_sel (
    .exc_req (exc_req),
    .exc_type(exc_type),
    .sw_req  (sw_req),
    .sw_type (sw_type),
    .cso_req (cso_req),
    .nmi_pend(nmi_pend),
    .intr    (intr),
    .if_eff  (if_eff),
    .tf_eff  (tf_eff),
    .blk_eff (blk_eff),
    .hit     (sel_hit),
    .src     (sel_src),
    .typ     (sel_type)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      type_q  <= '0;
      src_q   <= SRC_EXC;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          src_q  <= sel_src;
          type_q <= sel_type;
          state_q <= (sel_src == SRC_INTR) ? ST_ACKW : ST_SHOW;
        end
        ST_ACKW: if (ack_done) begin
          type_q  <= ack_type;
          state_q <= ST_SHOW;
        end
        ST_SHOW: if (svc_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_req   = (state_q == ST_ACKW);
  assign svc_valid = (state_q == ST_SHOW);
  assign svc_type  = type_q;
  assign svc_src   = src_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int TYPE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_req,
  input logic              flag_we,
  input logic              flag_if,
  input logic              iret,
  input logic              iret_if,
  input logic              svc_valid,
  input logic              svc_ready,
  input logic [TYPE_W-1:0] svc_type,
  input logic [2:0]        svc_src,
  input logic              if_flag,
  input logic              tf_flag,
  input logic              nmi_blocked
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && !svc_ready |=> svc_valid && $stable(svc_type) && $stable(svc_src));

  p_nmi_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_src == 3'd3 |-> svc_type == TYPE_W'(2));

  p_step_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_src == 3'd5 |-> svc_type == TYPE_W'(1));

  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid || ack_req |-> !if_flag && !tf_flag);

  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_blocked && svc_valid |-> svc_src == 3'd0 || svc_src == 3'd1 || svc_src == 3'd3);

  p_intr_if_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(iret ? iret_if : (flag_we ? flag_if : if_flag)));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_req && svc_valid));
endmodule

bind irq_arbiter irq_arbiter_chk #(.TYPE_W(TYPE_W)) u_chk (.*);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic boundary, exc_req, sw_req, cso_req, nmi, intr, ack_done;
  logic [7:0] exc_type, sw_type, ack_type;
  logic flag_we, flag_if, flag_tf, iret, iret_if, iret_tf, svc_ready;
  logic ack_req, svc_valid, if_flag, tf_flag, nmi_blocked;
  logic [7:0] svc_type;
  logic [2:0] svc_src;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit m_if, m_tf, m_blk, m_np;

  always #2 clk = ~clk;

  irq_arbiter u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int pick(bit e, bit s, bit c, bit np, bit i, bit f, bit t, bit b);
    if (e) return 0;
    if (s) return 1;
    if (c && !b) return 2;
    if (np && !b) return 3;
    if (i && f && !b) return 4;
    if (t && !b) return 5;
    return 7;
  endfunction

  task automatic wflags(bit a, bit b);
    flag_we = 1; flag_if = a; flag_tf = b; step(); flag_we = 0;
    m_if = a; m_tf = b;
  endtask

  task automatic do_iret(bit a, bit b);
    iret = 1; iret_if = a; iret_tf = b; step(); iret = 0;
    m_if = a; m_tf = b; m_blk = 0;
  endtask

  task automatic nmi_pulse();
    nmi = 1; step(); nmi = 0; step();
    m_np = 1;
  endtask

  task automatic bnd();
    boundary = 1; step(); boundary = 0;
  endtask

  task automatic take();
    svc_ready = 1; step(); svc_ready = 0;
  endtask

  task automatic expect_svc(string req, int src, logic [7:0] typ);
    chk(req, svc_valid, 1);
    chk(req, svc_src, src);
    chk(req, svc_type, typ);
    m_if = 0; m_tf = 0;
    if (src == 3) begin m_blk = 1; m_np = 0; end
  endtask

  task automatic clr_req();
    exc_req = 0; sw_req = 0; cso_req = 0; intr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0286);
    rst_n = 0; boundary = 0; exc_req = 0; sw_req = 0; cso_req = 0; nmi = 0; intr = 0;
    ack_done = 0; exc_type = 0; sw_type = 0; ack_type = 0; flag_we = 0; flag_if = 0;
    flag_tf = 0; iret = 0; iret_if = 0; iret_tf = 0; svc_ready = 0;
    m_if = 0; m_tf = 0; m_blk = 0; m_np = 0;
    repeat (3) step();
    chk("R1 svc_valid", svc_valid, 0);
    chk("R1 ack_req", ack_req, 0);
    chk("R1 flags", {if_flag, tf_flag}, 0);
    chk("R1 nmi_blocked", nmi_blocked, 0);
    rst_n = 1; step();

    // R9 flag write, R11 type 00h, R8 clear on entry
    wflags(1, 1);
    chk("R9 flag write", {if_flag, tf_flag}, 2'b11);
    exc_req = 1; exc_type = 8'h00; bnd(); clr_req();
    expect_svc("R11 fault type 00", 0, 8'h00);
    chk("R8 flags cleared", {if_flag, tf_flag}, 2'b00);
    take();
    sw_req = 1; sw_type = 8'hFF; bnd(); clr_req();
    expect_svc("R11 soft type FF", 1, 8'hFF);
    take();

    // R2 priority ladder
    nmi_pulse();
    do_iret(1, 1);
    exc_req = 1; sw_req = 1; cso_req = 1; intr = 1; exc_type = 8'h00; sw_type = 8'h21;
    bnd(); clr_req();
    expect_svc("R2 fault first", 0, 8'h00); take();
    do_iret(1, 1);
    sw_req = 1; cso_req = 1; intr = 1; bnd(); clr_req();
    expect_svc("R2 soft before overrun", 1, 8'h21); take();
    do_iret(1, 1);
    cso_req = 1; intr = 1; bnd(); clr_req();
    expect_svc("R2 overrun before nmi", 2, 8'h09); take();
    do_iret(1, 1);
    intr = 1; bnd();
    expect_svc("R2 nmi before intr", 3, 8'h02);
    chk("R3 no ack for nmi", ack_req, 0);
    chk("R4 block set", nmi_blocked, 1);
    take(); clr_req();

    // R3 held level gives one service
    do_iret(0, 0);
    nmi = 1; repeat (4) step(); m_np = 1;
    bnd(); expect_svc("R3 held nmi", 3, 8'h02); take();
    do_iret(0, 0);
    bnd(); chk("R3 no retrigger", svc_valid, 0);
    nmi = 0; step();

    // R4 / R5 block behaviour
    nmi_pulse(); bnd(); expect_svc("R4 enter nmi", 3, 8'h02); take();
    nmi_pulse();
    wflags(1, 1);
    intr = 1; cso_req = 1; bnd(); clr_req();
    chk("R4 blocked nothing served", svc_valid | ack_req, 0);
    sw_req = 1; sw_type = 8'h80; bnd(); clr_req();
    expect_svc("R4 soft passes block", 1, 8'h80); take();
    chk("R4 still blocked", nmi_blocked, 1);
    do_iret(1, 0);
    chk("R4 iret releases", nmi_blocked, 0);
    intr = 1; bnd(); clr_req();
    expect_svc("R5 held edge served", 3, 8'h02); take();
    do_iret(0, 0);

    // R6 maskable path
    intr = 1; bnd();
    chk("R6 masked when IF=0", svc_valid | ack_req, 0);
    wflags(1, 0);
    bnd(); clr_req();
    chk("R6 ack raised", ack_req, 1);
    repeat (3) step();
    chk("R6 waits ack", {ack_req, svc_valid}, 2'b10);
    ack_done = 1; ack_type = 8'h5A; step(); ack_done = 0;
    expect_svc("R6 ext type", 4, 8'h5A);

    // R10 hold and ignore while busy; R9 ignored while busy
    exc_req = 1; exc_type = 8'h33; boundary = 1;
    flag_we = 1; flag_if = 1; flag_tf = 1;
    repeat (3) step();
    boundary = 0; flag_we = 0; clr_req();
    chk("R10 held valid", svc_valid, 1);
    chk("R10 held type", svc_type, 8'h5A);
    take();
    chk("R10 no new offer", svc_valid | ack_req, 0);
    chk("R9 write ignored busy", {if_flag, tf_flag}, 2'b00);

    // R7 single step
    wflags(0, 1);
    bnd(); expect_svc("R7 step type", 5, 8'h01);
    chk("R7 TF cleared", tf_flag, 0);
    take();

    // R9 iret with boundary same cycle
    iret = 1; iret_if = 0; iret_tf = 1; boundary = 1; step();
    iret = 0; boundary = 0;
    expect_svc("R9 iret before decision", 5, 8'h01); take();

    // random rounds
    for (int k = 0; k < 300; k++) begin
      int e;
      bit re, rs, rc, ri;
      logic [7:0] te, ts, ta;
      if ($urandom % 3 == 0) wflags(1'($urandom), 1'($urandom));
      if ($urandom % 4 == 0) nmi_pulse();
      re = ($urandom % 8 == 0); rs = ($urandom % 6 == 0);
      rc = ($urandom % 5 == 0); ri = 1'($urandom);
      te = 8'($urandom); ts = 8'($urandom);
      e = pick(re, rs, rc, m_np, ri, m_if, m_tf, m_blk);
      exc_req = re; sw_req = rs; cso_req = rc; intr = ri; exc_type = te; sw_type = ts;
      bnd(); clr_req();
      if (e == 7) chk("R2 random idle", svc_valid | ack_req, 0);
      else if (e == 4) begin
        chk("R6 random ack", ack_req, 1);
        repeat ($urandom % 3) step();
        ta = 8'($urandom);
        ack_done = 1; ack_type = ta; step(); ack_done = 0;
        expect_svc("R6 random", 4, ta);
      end else begin
        case (e)
          0: expect_svc("R2 random fault", 0, te);
          1: expect_svc("R2 random soft", 1, ts);
          2: expect_svc("R2 random overrun", 2, 8'h09);
          3: expect_svc("R3 random nmi", 3, 8'h02);
          default: expect_svc("R7 random step", 5, 8'h01);
        endcase
      end
      if (e != 7) begin
        repeat ($urandom % 3) step();
        chk("R10 random hold", svc_valid, 1);
        take();
      end
      chk("R8 random flags", {if_flag, tf_flag}, {m_if, m_tf});
      chk("R4 random block", nmi_blocked, m_blk);
      if ($urandom % 3 == 0) do_iret(1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule